// File: doc/BRIEF.md
# Serial Transmit Framing Interface

This block sits on the transmit side between a host MAC and a spreading modulator. When the host raises its transmit enable, the block starts a sequencer. If header generation is on, the sequencer first sends a run of preamble ones, then a fixed 16-bit start delimiter, then a 32-bit header word taken from configuration inputs. It then raises a ready flag. After that it takes payload bits serially from the host and passes them on to the modulator.

The block generates the host-facing bit clock itself by dividing the master clock. A configuration bit chooses whether the host data line is sampled on the falling edge of that clock (the default) or on the rising edge. Every bit sent to the modulator appears on a serial output together with a one-cycle strobe. Dropping the enable stops everything and returns the sequencer to idle.

Top module: `txf_top`

## Requirements
- R1: The bit clock output toggles every N master cycles while a transmission runs, where N is 1, 2, 4 or 8 for rate_sel values 0, 1, 2 and 3. Consecutive bit strobes are therefore exactly 2N master cycles apart, and a strobe is never high for two cycles in a row.
- R2: With hdr_en high, the bit stream starts with pre_len ones. It continues with the start delimiter 16'hF3A0, bit 0 first, and then hdr_word, bit 0 first, so byte 0 goes first and each byte goes least significant bit first. A pre_len of 0 goes straight to the delimiter.
- R3: Payload bits leave on ser_out in the order they were sampled from txd, so a host that supplies its word least significant bit first sees it forwarded in that order.
- R4: With samp_rise = 0, txd is sampled when the bit clock falls. If tx_en is first seen high at clock edge E0, the first strobe is high in the cycle after edge E0+2N. With samp_rise = 1, txd is sampled when the bit clock rises, and the first strobe follows edge E0+N.
- R5: With hdr_en high, tx_rdy rises in the same cycle as the strobe of the last header bit and stays high through the whole payload.
- R6: One cycle after tx_en falls, tx_rdy, bclk_o and bit_stb are all low. A later rising edge of tx_en restarts the frame from its first preamble bit.
- R7: With hdr_en low, tx_rdy never rises, and the first strobed bit is the txd value sampled at the first sampling edge.
- R8: bclk_o is low whenever tx_en has been low at the preceding clock edge, including before any transmission.
- R9: A synchronous active-high rst forces the outputs low and the sequencer to idle. If tx_en is still high when rst is released, no transmission starts until tx_en goes low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable from host; wraps the whole frame |
| txd | input | 1 | Serial payload data from host |
| rate_sel | input | 2 | Bit clock divide select: half period of 1, 2, 4 or 8 master cycles |
| samp_rise | input | 1 | 0: sample txd on the falling bit clock edge, 1: on the rising edge |
| hdr_en | input | 1 | 1: send preamble, delimiter and header before payload |
| pre_len | input | 8 | Number of preamble ones |
| hdr_word | input | 32 | Header word |
| bclk_o | output | 1 | Bit clock to host |
| tx_rdy | output | 1 | High once the header has been sent, until enable drops |
| ser_out | output | 1 | Serial bit to modulator, valid during bit_stb |
| bit_stb | output | 1 | One-cycle strobe per transmitted bit |

## Verification
The bench goes after the first-bit latency for both sampling edges and all four divide settings. A design that sampled on the wrong phase would shift that latency by N cycles and would pick up txd values the host had not yet settled. It covers a zero-length preamble, which a design with an off-by-one preamble counter would instead turn into a 256-bit run. It also checks the exact strobe at which ready rises, since a ready that came one bit late would cause the first payload bit to be lost. It stops a frame in the middle of the preamble and then restarts it, to catch a sequencer that resumes where it left off instead of going back to the first preamble bit. Finally it releases reset while enable is still high, which a level-triggered start would wrongly treat as a new frame.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_HDR,
        ST_PAY
    } txf_state_e;

    localparam int          SFD_BITS = 16;
    localparam logic [15:0] TXF_SFD  = 16'hF3A0;

    // Terminal count of the half-period counter for a given divide select:
    // the low 'sel' bits set, i.e. 2**sel - 1.
    function automatic logic [7:0] half_limit(input logic [2:0] sel);
        return ~(8'hFF << sel);
    endfunction

endpackage

// File: rtl/txf_clkgen.sv
module txf_clkgen #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              samp_rise,
    output logic              bclk,
    output logic              tick
);
    import txf_pkg::*;

    localparam int CNT_W = (1 << RATE_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             last;

    assign lim  = CNT_W'(half_limit(3'(rate_sel)));
    assign last = run && (cnt == lim);
    // A sampling tick marks the master edge at which bclk makes the chosen transition.
    assign tick = last && (samp_rise ? !bclk : bclk);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (last) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/txf_bitmux.sv
module txf_bitmux #(
    parameter int IDX_W = 8,
    parameter int HDR_W = 32
) (
    input  txf_pkg::txf_state_e state,
    input  logic [IDX_W-1:0]    idx,
    input  logic [HDR_W-1:0]    hdr_word,
    input  logic                txd,
    output logic                bit_o
);
    import txf_pkg::*;

    localparam int HI_W = $clog2(HDR_W);
    localparam int SI_W = $clog2(SFD_BITS);

    always_comb begin
        case (state)
            ST_PRE:  bit_o = 1'b1;
            ST_SFD:  bit_o = TXF_SFD[idx[SI_W-1:0]];
            ST_HDR:  bit_o = hdr_word[idx[HI_W-1:0]];
            ST_PAY:  bit_o = txd;
            default: bit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/txf_seq.sv
module txf_seq #(
    parameter int PRE_W = 8,
    parameter int HDR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             txd,
    input  logic             hdr_en,
    input  logic [PRE_W-1:0] pre_len,
    input  logic [HDR_W-1:0] hdr_word,
    input  logic             tick,
    output logic             run,
    output logic             ser_out,
    output logic             bit_stb,
    output logic             tx_rdy
);
    import txf_pkg::*;

    localparam int HI_W  = $clog2(HDR_W);
    localparam int IDX_W = (PRE_W > HI_W) ? PRE_W : HI_W;

    txf_state_e       state;
    txf_state_e       start_st;
    logic [IDX_W-1:0] idx;
    logic             en_q;
    logic             nxt_bit;

    assign run = (state != ST_IDLE) && tx_en;

    always_comb begin
        if (!hdr_en)              start_st = ST_PAY;
        else if (pre_len == '0)   start_st = ST_SFD;
        else                      start_st = ST_PRE;
    end

    txf_bitmux #(.IDX_W(IDX_W), .HDR_W(HDR_W)) u_mux (
        .state    (state),
        .idx      (idx),
        .hdr_word (hdr_word),
        .txd      (txd),
        .bit_o    (nxt_bit)
    );

    always_ff @(posedge clk) begin
        en_q <= tx_en;
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            ser_out <= 1'b0;
            bit_stb <= 1'b0;
            tx_rdy  <= 1'b0;
        end else begin
            bit_stb <= 1'b0;
            if (!tx_en) begin
                state   <= ST_IDLE;
                idx     <= '0;
                ser_out <= 1'b0;
                tx_rdy  <= 1'b0;
            end else if (state == ST_IDLE) begin
                if (!en_q) begin
                    state <= start_st;
                    idx   <= '0;
                end
            end else if (tick) begin
                ser_out <= nxt_bit;
                bit_stb <= 1'b1;
                idx     <= idx + 1'b1;
                case (state)
                    ST_PRE: if (idx == IDX_W'(pre_len - 1'b1)) begin
                        state <= ST_SFD;
                        idx   <= '0;
                    end
                    ST_SFD: if (idx == IDX_W'(SFD_BITS - 1)) begin
                        state <= ST_HDR;
                        idx   <= '0;
                    end
                    ST_HDR: if (idx == IDX_W'(HDR_W - 1)) begin
                        state  <= ST_PAY;
                        idx    <= '0;
                        tx_rdy <= 1'b1;
                    end
                    default: idx <= '0;
                endcase
            end
        end
    end

    // R5
    rdy_with_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_rdy) |-> (bit_stb && state == ST_PAY));

    // R7
    nohdr_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && tx_en && !en_q && !hdr_en) |=> (state == ST_PAY && !tx_rdy));

endmodule

// File: rtl/txf_top.sv
module txf_top #(
    parameter int RATE_W = 2,
    parameter int PRE_W  = 8,
    parameter int HDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              txd,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              samp_rise,
    input  logic              hdr_en,
    input  logic [PRE_W-1:0]  pre_len,
    input  logic [HDR_W-1:0]  hdr_word,
    output logic              bclk_o,
    output logic              tx_rdy,
    output logic              ser_out,
    output logic              bit_stb
);

    logic run;
    logic tick;

    txf_clkgen #(.RATE_W(RATE_W)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .rate_sel  (rate_sel),
        .samp_rise (samp_rise),
        .bclk      (bclk_o),
        .tick      (tick)
    );

    txf_seq #(.PRE_W(PRE_W), .HDR_W(HDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .txd      (txd),
        .hdr_en   (hdr_en),
        .pre_len  (pre_len),
        .hdr_word (hdr_word),
        .tick     (tick),
        .run      (run),
        .ser_out  (ser_out),
        .bit_stb  (bit_stb),
        .tx_rdy   (tx_rdy)
    );

    // R6
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_en) |=> (!tx_rdy && !bclk_o && !bit_stb));

    // R8
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !bclk_o);

    // R1
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

endmodule

// File: tb/tb_txf_top.sv
`timescale 1ns/1ps
module tb_txf_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        tx_en;
    logic        txd;
    logic [1:0]  rate_sel;
    logic        samp_rise;
    logic        hdr_en;
    logic [7:0]  pre_len;
    logic [31:0] hdr_word;
    logic        bclk_o, tx_rdy, ser_out, bit_stb;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    txf_top dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .txd(txd), .rate_sel(rate_sel),
        .samp_rise(samp_rise), .hdr_en(hdr_en), .pre_len(pre_len), .hdr_word(hdr_word),
        .bclk_o(bclk_o), .tx_rdy(tx_rdy), .ser_out(ser_out), .bit_stb(bit_stb)
    );

    typedef struct packed {
        logic [1:0]  rate;
        logic        rise;
        logic        hdr;
        logic [7:0]  pre;
        logic [31:0] hw;
        logic [15:0] pay;
        logic [4:0]  npay;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 1'b0, 1'b1, 8'd4, 32'hA5C30F81, 16'hB2D4, 5'd12},
        '{2'd1, 1'b1, 1'b1, 8'd7, 32'h12345678, 16'h00FF, 5'd8},
        '{2'd2, 1'b0, 1'b0, 8'd3, 32'h00000000, 16'h6C39, 5'd16},
        '{2'd3, 1'b1, 1'b1, 8'd0, 32'hDEADBEEF, 16'h0005, 5'd4},
        '{2'd0, 1'b1, 1'b0, 8'd0, 32'h00000000, 16'h9A1E, 5'd10},
        '{2'd3, 1'b0, 1'b1, 8'd2, 32'h80000001, 16'h4001, 5'd16}
    };

    localparam logic [15:0] DELIM = 16'hF3A0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Runs one frame; stops after 'limit' bits when limit >= 0.
    task automatic run_frame(input vec_t v, input int limit);
        int  n     = 1 << v.rate;
        int  hb    = v.hdr ? (int'(v.pre) + 48) : 0;
        int  total = hb + int'(v.npay);
        int  k     = 0;
        int  cyc   = 0;
        int  last  = 0;
        logic e [128];
        for (int i = 0; i < 128; i++) e[i] = 1'b0;
        for (int i = 0; i < hb; i++) begin
            if (i < int'(v.pre))             e[i] = 1'b1;
            else if (i < int'(v.pre) + 16)   e[i] = DELIM[i - int'(v.pre)];
            else                             e[i] = v.hw[i - int'(v.pre) - 16];
        end
        for (int i = 0; i < int'(v.npay); i++) e[hb + i] = v.pay[i];
        if (limit >= 0 && limit < total) total = limit;

        @(negedge clk);
        rate_sel  = v.rate;
        samp_rise = v.rise;
        hdr_en    = v.hdr;
        pre_len   = v.pre;
        hdr_word  = v.hw;
        txd       = v.hdr ? 1'b0 : v.pay[0];
        tx_en     = 1'b1;
        while (k < total && cyc < 5000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (bit_stb) begin
                if (k == 0)
                    chk(cyc == (v.rise ? n + 1 : 2 * n + 1), "R4 first-strobe latency", cyc, v.rise ? n + 1 : 2 * n + 1);
                else
                    chk(cyc - last == 2 * n, "R1 strobe spacing", cyc - last, 2 * n);
                last = cyc;
                if (k < hb) chk(ser_out == e[k], "R2 framing bit", ser_out, e[k]);
                else        chk(ser_out == e[k], "R3 payload bit", ser_out, e[k]);
                if (v.hdr) chk(tx_rdy == (k >= hb - 1), "R5 ready timing", tx_rdy, k >= hb - 1);
                else       chk(tx_rdy == 1'b0, "R7 ready without header", tx_rdy, 0);
                if (k - hb + 1 >= 0 && k - hb + 1 < int'(v.npay)) txd = v.pay[k - hb + 1];
                k++;
            end
        end
        chk(k == total, "R1 bit count before timeout", k, total);
        tx_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk({tx_rdy, bclk_o, bit_stb} == 3'b000, "R6 quiet after enable drop", {tx_rdy, bclk_o, bit_stb}, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bclk_o || bit_stb) begin
                chk(1'b0, "R8 clock low while idle", {bclk_o, bit_stb}, 0);
                break;
            end
        end
    endtask

    initial begin
        rst = 1'b1; tx_en = 1'b0; txd = 1'b0; rate_sel = 2'd0; samp_rise = 1'b0;
        hdr_en = 1'b0; pre_len = 8'd0; hdr_word = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({bclk_o, tx_rdy, ser_out, bit_stb} == 4'b0000, "R9 reset state", {bclk_o, tx_rdy, ser_out, bit_stb}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(bclk_o == 1'b0, "R8 clock low before first frame", bclk_o, 0);

        for (int i = 0; i < 6; i++) run_frame(VECS[i], -1);

        // R6: stop in the middle of the preamble, then restart from the first bit.
        run_frame(VECS[0], 3);
        run_frame(VECS[0], -1);

        // R9: reset with enable held high, no restart without a new rising edge.
        @(negedge clk);
        rate_sel = 2'd0; samp_rise = 1'b0; hdr_en = 1'b0; txd = 1'b1; tx_en = 1'b1;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk({bclk_o, tx_rdy, bit_stb} == 3'b000, "R9 outputs low after reset", {bclk_o, tx_rdy, bit_stb}, 0);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (bit_stb || bclk_o) seen = 1'b1;
            end
            chk(!seen, "R9 no restart while enable held", seen, 0);
        end
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        run_frame(VECS[4], -1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired act=0 exp=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule